// File: doc/BRIEF.md
# Half-Duplex SPI Command-Buffer Master

This block is an SPI master behind a 32-bit register bus. Software loads an opcode word and a data window, then sets three bit counts. One start command then runs a single shift sequence on the pins. The sequence has an opcode phase, followed by either a transmit-data phase or a receive-data phase. The SPI clock comes from a programmable divider. Software picks the clock polarity, the clock phase and the bit order within a byte.

The chip selects are not driven by the sequencer. They follow a one-hot chip-select register, so one SPI message can span any number of start commands. Software polls a busy flag to learn when a sequence has finished. It then reads received bytes back from the same data window, which uses the same little-endian byte packing.

There is no data stream at the edge of this block. The bus and the pins are plain control and status signals, so no valid/ready back-pressure applies. The bus read data is combinational from the address, and writes take effect on the clock edge where `bus_sel` and `bus_wr` are both high.

Top module: `spi_cb_master`

## Requirements
- R1: After reset, `busy`, `spi_sclk` and `spi_mosi` are 0 and `spi_cs_n` is all ones. The registers at 0x00, 0x04, 0x28, 0x2C and 0x38 read 0.
- R2: A write to 0x00 with bit 8 set, made while idle and with a nonzero effective bit count, raises `busy` on the next cycle. `busy` then stays high for exactly (opcode bits + data bits) × (D+2) cycles. `busy` also reads back at 0x00 bit 16. A start written while busy is ignored. A start with all counts zero leaves `busy` low.
- R3: Each bit lasts D+2 clocks, where D is bits 27:16 of 0x28. Let h = floor((D+2)/2). With CPHA (0x28 bit 5) clear, SCLK sits at the CPOL level (0x28 bit 4) for the first h clocks of the bit and at the opposite level for the rest. With CPHA set, the two halves are swapped. When not busy, SCLK sits at CPOL. MOSI changes only at the start of a bit.
- R4: The opcode phase sends n = min(count, 32) bits, where the count is 0x2C bits 29:24. The opcode is right-justified in 0x04 over ceil(n/8) bytes, and those bytes go out most significant byte first. A zero count skips the phase.
- R5: The transmit phase sends min(count, 256) bits, where the count is 0x2C bits 8:0. Byte k comes from word k/4 of the window at 0x08 + 4·(k/4), at bit position (k%4)·8.
- R6: Within each byte, bit 7 goes first by default. Setting 0x28 bit 3 sends bit 0 first instead. The same order applies to the opcode, the transmit data and the receive data.
- R7: When the transmit count is 0, the data phase receives min(count, 256) bits, where the count is 0x2C bits 20:12. With CPHA clear, MISO is sampled in the last clock before SCLK leaves the idle level. With CPHA set, it is sampled in the last clock of the bit. Received bits are stored with the R5/R6 packing, and window bits beyond the count are unchanged. MOSI is low during receive and while idle.
- R8: When the transmit count is nonzero, the receive count is ignored and no window bit changes.
- R9: `spi_cs_n[n]` is low exactly when bit n of the register at 0x38 is set. A write keeps only the lowest set bit, so at most one select is active. The register stays writable while busy.
- R10: While busy, writes to 0x00, 0x04, the window, 0x28 and 0x2C are ignored.
- R11: Count fields larger than the capacity saturate: the opcode count to 32 bits, and the transmit and receive counts to 256 bits.
- R12: 0x28 reads back the divider, the mode bits 5:2 and the slave-select field 31:29. 0x2C reads back its three counts in place. 0x00 reads back the legacy fields at bits 20:19 and 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, used together with bus_sel |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | NCS | Active-low chip selects |
| busy | output | 1 | High while a sequence runs |

## Verification
The bench goes after the following corner cases, and each one names the failure it would catch:
- An odd divider (D = 3). A design that splits the SCLK halves wrongly shows SCLK mismatches in mid-bit.
- Both phase settings. A design that samples on the wrong edge stores shifted receive bytes.
- An LSB-first opcode of two bytes. A design that gets the byte order or the right-justification wrong drives the wrong MOSI bit in the first cycle.
- A receive of a partial word. A design that writes past the bit count corrupts a pre-filled neighbour byte.
- Pokes written in mid-sequence. Writes to the opcode register, a start command and a write to the count register must all leave MOSI and the busy length untouched, while a chip-select change in the same sequence must show up one cycle later.
- A sequence with the transmit and receive counts both set. A design that receives anyway changes the window.
- Counts above capacity. A design without saturation runs too long or wraps.
- A start with all counts zero. A design that raises busy anyway fails that check.

// File: rtl/spi_cb_pkg.sv
package spi_cb_pkg;
  localparam logic [7:0] ADR_XFER = 8'h00;
  localparam logic [7:0] ADR_OPC  = 8'h04;
  localparam logic [7:0] ADR_WIN0 = 8'h08;
  localparam logic [7:0] ADR_MCTL = 8'h28;
  localparam logic [7:0] ADR_CNT  = 8'h2C;
  localparam logic [7:0] ADR_CSEL = 8'h38;

  typedef enum logic {PH_OP, PH_DATA} phase_t;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic lsb;
  } spi_mode_t;
endpackage

// File: rtl/spi_cb_regs.sv
module spi_cb_regs
  import spi_cb_pkg::*;
#(
  parameter int NCS       = 4,
  parameter int DIVW      = 12,
  parameter int WIN_WORDS = 8,
  parameter int OCW       = 6,
  parameter int CW        = 9,
  localparam int WIN_BITS = WIN_WORDS * 32,
  localparam int IW       = $clog2(WIN_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [7:0]          bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                busy,
  input  logic                rx_we,
  input  logic [IW-1:0]       rx_idx,
  input  logic                rx_val,
  output logic                start,
  output logic [31:0]         opcode,
  output logic [WIN_BITS-1:0] win,
  output logic [DIVW-1:0]     div,
  output spi_mode_t           mode,
  output logic [OCW-1:0]      op_cnt,
  output logic [CW-1:0]       tx_cnt,
  output logic [CW-1:0]       rx_cnt,
  output logic [NCS-1:0]      cs_sel
);
  logic wr, wr_cfg;
  logic [1:0] leg_asz;
  logic [3:0] leg_bcnt;
  logic [2:0] ssel;
  logic       bufm;
  logic [WIN_WORDS-1:0][31:0] win_q;
  logic [NCS-1:0] cs_in;
  logic unused_wbits;

  assign wr     = bus_sel & bus_wr;
  assign wr_cfg = wr & ~busy;
  assign start  = wr_cfg && (bus_addr == ADR_XFER) && bus_wdata[8];
  assign cs_in  = bus_wdata[NCS-1:0];
  assign unused_wbits = ^{bus_wdata[28], bus_wdata[15:6], bus_wdata[1:0],
                          bus_wdata[31:30], bus_wdata[23:21], bus_wdata[11:9],
                          bus_wdata[18:9]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      leg_asz  <= '0;
      leg_bcnt <= '0;
      opcode   <= '0;
      div      <= '0;
      mode     <= '0;
      ssel     <= '0;
      bufm     <= 1'b0;
      op_cnt   <= '0;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
    end else if (wr_cfg) begin
      case (bus_addr)
        ADR_XFER: begin
          leg_asz  <= bus_wdata[20:19];
          leg_bcnt <= bus_wdata[3:0];
        end
        ADR_OPC:  opcode <= bus_wdata;
        ADR_MCTL: begin
          div       <= bus_wdata[16 +: DIVW];
          mode.cpha <= bus_wdata[5];
          mode.cpol <= bus_wdata[4];
          mode.lsb  <= bus_wdata[3];
          bufm      <= bus_wdata[2];
          ssel      <= bus_wdata[31:29];
        end
        ADR_CNT: begin
          op_cnt <= bus_wdata[24 +: OCW];
          rx_cnt <= bus_wdata[12 +: CW];
          tx_cnt <= bus_wdata[0 +: CW];
        end
        default: ;
      endcase
    end
  end

  // chip select keeps lowest set bit only, writable at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_sel <= '0;
    else if (wr && bus_addr == ADR_CSEL) cs_sel <= cs_in & (~cs_in + 1'b1);
  end

  for (genvar w = 0; w < WIN_WORDS; w++) begin : g_win
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_q[w] <= '0;
      else if (wr_cfg && bus_addr == ADR_WIN0 + 8'(4 * w)) win_q[w] <= bus_wdata;
      else if (rx_we && rx_idx[IW-1:5] == (IW-5)'(w)) win_q[w][rx_idx[4:0]] <= rx_val;
    end
    assign win[w*32 +: 32] = win_q[w];
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADR_XFER: bus_rdata = {11'b0, leg_asz, 2'b0, busy, 12'b0, leg_bcnt};
      ADR_OPC:  bus_rdata = opcode;
      ADR_MCTL: bus_rdata = {ssel, 1'b0, 12'(div), 10'b0, mode.cpha, mode.cpol,
                             mode.lsb, bufm, 2'b0};
      ADR_CNT:  bus_rdata = {2'b0, 6'(op_cnt), 3'b0, 9'(rx_cnt), 3'b0, 9'(tx_cnt)};
      ADR_CSEL: bus_rdata = 32'(cs_sel);
      default: begin
        for (int w = 0; w < WIN_WORDS; w++)
          if (bus_addr == ADR_WIN0 + 8'(4 * w)) bus_rdata = win_q[w];
      end
    endcase
  end
endmodule

// File: rtl/spi_cb_clkgen.sv
module spi_cb_clkgen #(
  parameter int DIVW = 12,
  localparam int TW  = DIVW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  input  logic            cpol,
  input  logic            cpha,
  output logic            sclk,
  output logic            bit_end,
  output logic            sample
);
  logic [TW-1:0] tick, period, half;
  logic          active;

  assign period  = {1'b0, div} + TW'(2);
  assign half    = period >> 1;
  assign bit_end = run && (tick == period - 1'b1);
  assign active  = cpha ? (tick < half) : (tick >= half);
  assign sclk    = cpol ^ (run & active);
  assign sample  = run && (cpha ? (tick == period - 1'b1) : (tick == half - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick <= '0;
    else if (!run)    tick <= '0;
    else if (bit_end) tick <= '0;
    else              tick <= tick + 1'b1;
  end
endmodule

// File: rtl/spi_cb_seq.sv
module spi_cb_seq
  import spi_cb_pkg::*;
#(
  parameter int OP_BITS  = 32,
  parameter int WIN_BITS = 256,
  parameter int OCW      = 6,
  parameter int CW       = 9,
  localparam int NW      = $clog2(WIN_BITS + 1),
  localparam int IW      = $clog2(WIN_BITS),
  localparam int OW      = $clog2(OP_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [OCW-1:0]      op_f,
  input  logic [CW-1:0]       tx_f,
  input  logic [CW-1:0]       rx_f,
  input  logic                lsb,
  input  logic [31:0]         opcode,
  input  logic [WIN_BITS-1:0] win,
  input  logic                bit_end,
  input  logic                sample,
  input  logic                miso,
  output logic                run,
  output logic                mosi,
  output logic                rx_we,
  output logic [IW-1:0]       rx_idx,
  output logic                rx_val
);
  logic [NW-1:0] op_cap, tx_cap, rx_cap, dat_cap;
  logic [NW-1:0] op_n_q, dat_n_q, bit_q, cur_n, op_nb, op_byte;
  logic          rx_dir_q;
  phase_t        ph_q;
  logic [2:0]    pos;
  logic [OW-1:0] op_sel;
  logic [IW-1:0] widx;
  logic          unused_seq;

  assign op_cap  = (op_f > OCW'(OP_BITS)) ? NW'(OP_BITS) : NW'(op_f);
  assign tx_cap  = (tx_f > CW'(WIN_BITS)) ? NW'(WIN_BITS) : NW'(tx_f);
  assign rx_cap  = (rx_f > CW'(WIN_BITS)) ? NW'(WIN_BITS) : NW'(rx_f);
  assign dat_cap = (tx_cap != '0) ? tx_cap : rx_cap;
  assign cur_n   = (ph_q == PH_OP) ? op_n_q : dat_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      ph_q     <= PH_OP;
      bit_q    <= '0;
      op_n_q   <= '0;
      dat_n_q  <= '0;
      rx_dir_q <= 1'b0;
    end else if (start && !run) begin
      op_n_q   <= op_cap;
      dat_n_q  <= dat_cap;
      rx_dir_q <= (tx_cap == '0);
      bit_q    <= '0;
      if (op_cap != '0) begin
        run  <= 1'b1;
        ph_q <= PH_OP;
      end else if (dat_cap != '0) begin
        run  <= 1'b1;
        ph_q <= PH_DATA;
      end
    end else if (bit_end) begin
      if (bit_q == cur_n - 1'b1) begin
        bit_q <= '0;
        if (ph_q == PH_OP && dat_n_q != '0) ph_q <= PH_DATA;
        else                                run  <= 1'b0;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // bit order within a byte, byte order per phase
  assign pos     = lsb ? bit_q[2:0] : ~bit_q[2:0];
  assign op_nb   = (op_n_q + NW'(7)) >> 3;
  assign op_byte = op_nb - 1'b1 - (bit_q >> 3);
  assign op_sel  = {op_byte[OW-4:0], pos};
  assign widx    = {bit_q[IW-1:3], pos};

  always_comb begin
    mosi = 1'b0;
    if (run) begin
      if (ph_q == PH_OP) mosi = opcode[op_sel];
      else               mosi = ~rx_dir_q & win[widx];
    end
  end

  assign rx_we      = sample && (ph_q == PH_DATA) && rx_dir_q;
  assign rx_idx     = widx;
  assign rx_val     = miso;
  assign unused_seq = ^{op_byte[NW-1:OW-3], bit_q[NW-1:IW]};
endmodule

// File: rtl/spi_cb_master.sv
module spi_cb_master
  import spi_cb_pkg::*;
#(
  parameter int NCS       = 4,
  parameter int DIVW      = 12,
  parameter int WIN_WORDS = 8,
  localparam int WIN_BITS = WIN_WORDS * 32,
  localparam int IW       = $clog2(WIN_BITS),
  localparam int OCW      = 6,
  localparam int CW       = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [7:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic           spi_sclk,
  output logic           spi_mosi,
  input  logic           spi_miso,
  output logic [NCS-1:0] spi_cs_n,
  output logic           busy
);
  logic                start, rx_we, rx_val, bit_end, sample, run;
  logic [IW-1:0]       rx_idx;
  logic [31:0]         opcode;
  logic [WIN_BITS-1:0] win;
  logic [DIVW-1:0]     div;
  spi_mode_t           mode;
  logic [OCW-1:0]      op_cnt;
  logic [CW-1:0]       tx_cnt, rx_cnt;
  logic [NCS-1:0]      cs_sel;
  logic                mode_cpol, mode_cpha;

  assign mode_cpol = mode.cpol;
  assign mode_cpha = mode.cpha;
  assign busy      = run;
  assign spi_cs_n  = ~cs_sel;

  spi_cb_regs #(.NCS(NCS), .DIVW(DIVW), .WIN_WORDS(WIN_WORDS), .OCW(OCW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(run), .rx_we(rx_we),
    .rx_idx(rx_idx), .rx_val(rx_val), .start(start), .opcode(opcode), .win(win),
    .div(div), .mode(mode), .op_cnt(op_cnt), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
    .cs_sel(cs_sel)
  );

  spi_cb_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run), .div(div), .cpol(mode.cpol), .cpha(mode.cpha),
    .sclk(spi_sclk), .bit_end(bit_end), .sample(sample)
  );

  spi_cb_seq #(.OP_BITS(32), .WIN_BITS(WIN_BITS), .OCW(OCW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_f(op_cnt), .tx_f(tx_cnt), .rx_f(rx_cnt),
    .lsb(mode.lsb), .opcode(opcode), .win(win), .bit_end(bit_end), .sample(sample),
    .miso(spi_miso), .run(run), .mosi(spi_mosi), .rx_we(rx_we), .rx_idx(rx_idx),
    .rx_val(rx_val)
  );
endmodule

// File: rtl/spi_cb_master_chk.sv
module spi_cb_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_sel,
  input logic           bus_wr,
  input logic [7:0]     bus_addr,
  input logic           start_bit,
  input logic           spi_sclk,
  input logic           spi_mosi,
  input logic [NCS-1:0] spi_cs_n,
  input logic           busy,
  input logic           cpol,
  input logic           cpha
);
  p_cs_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~spi_cs_n));

  p_cs_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spi_cs_n) |-> $past(bus_sel && bus_wr && bus_addr == 8'h38));

  p_start_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_sel && bus_wr && bus_addr == 8'h00 && start_bit));

  p_idle_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_sclk == cpol);

  p_mosi_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(spi_mosi)) |-> spi_sclk == (cpol ^ cpha));

  p_mosi_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_mosi);
endmodule

bind spi_cb_master spi_cb_master_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .start_bit(bus_wdata[8]), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
  .spi_cs_n(spi_cs_n), .busy(busy), .cpol(mode_cpol), .cpha(mode_cpha)
);

// File: tb/spi_cb_master_test.sv
module spi_cb_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sclk, spi_mosi, busy;
  logic spi_miso = 1'b0;
  logic [3:0] spi_cs_n;

  int checks = 0, errors = 0;
  logic [31:0] opv;
  logic [31:0] winm [8];
  int csm = 0;
  logic [255:0] rxpat;
  int dv = 0;
  bit cpol = 0, cpha = 0, lsb = 0;

  always #5 clk = ~clk;

  spi_cb_master uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sclk(spi_sclk),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .busy(busy)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_mode(int d, bit pol, bit pha, bit lf);
    dv = d; cpol = pol; cpha = pha; lsb = lf;
    wr(8'h28, (32'(d) << 16) | (32'(pha) << 5) | (32'(pol) << 4) | (32'(lf) << 3));
  endtask

  function automatic bit exp_bit(int j, int nop, bit rxdir);
    int bi, k, pos, nb, fl;
    if (j < nop) begin
      nb = (nop + 7) / 8; bi = j / 8; k = j % 8; pos = lsb ? k : 7 - k;
      return opv[(nb - 1 - bi) * 8 + pos];
    end
    if (rxdir) return 1'b0;
    bi = (j - nop) / 8; k = (j - nop) % 8; pos = lsb ? k : 7 - k;
    fl = bi * 8 + pos;
    return winm[fl / 32][fl % 32];
  endfunction

  task automatic run_xfer(int opf, int txf, int rxf, bit poke, string req);
    int nop, ntx, nrx, ndat, p, h, total, j, t, jd, fl;
    bit rxdir, act;
    logic [31:0] d;
    nop = (opf > 32) ? 32 : opf;
    ntx = (txf > 256) ? 256 : txf;
    nrx = (rxf > 256) ? 256 : rxf;
    rxdir = (ntx == 0);
    ndat = rxdir ? nrx : ntx;
    p = dv + 2; h = p / 2;
    total = (nop + ndat) * p;
    wr(8'h2C, (32'(opf) << 24) | (32'(rxf) << 12) | 32'(txf));
    wr(8'h00, 32'h100);
    rd(8'h00, d);
    chk("R2", "busy readback", d[16], 1);
    for (int k = 0; k < total; k++) begin
      bus_sel = 1'b0; bus_wr = 1'b0;
      if (poke && k == 9) csm = 8;
      if (poke && (k == 2 || k == 4 || k == 6 || k == 8)) begin
        bus_sel = 1'b1; bus_wr = 1'b1;
        case (k)
          2: begin bus_addr = 8'h04; bus_wdata = ~opv; end
          4: begin bus_addr = 8'h00; bus_wdata = 32'h100; end
          6: begin bus_addr = 8'h2C; bus_wdata = 32'h0; end
          default: begin bus_addr = 8'h38; bus_wdata = 32'h8; end
        endcase
      end
      j = k / p; t = k % p;
      act = cpha ? (t < h) : (t >= h);
      chk("R3", "sclk", spi_sclk, cpol ^ act);
      chk(req, "mosi", spi_mosi, exp_bit(j, nop, rxdir));
      chk("R2", "busy", busy, 1);
      chk("R9", "cs_n", spi_cs_n, ~csm & 4'hF);
      spi_miso = rxpat[j & 255];
      if (rxdir && j >= nop && t == (cpha ? p - 1 : h - 1)) begin
        jd = j - nop;
        fl = (jd / 8) * 8 + (lsb ? jd % 8 : 7 - jd % 8);
        winm[fl / 32][fl % 32] = rxpat[j & 255];
      end
      @(negedge clk);
    end
    bus_sel = 1'b0; bus_wr = 1'b0; spi_miso = 1'b0;
    chk("R2", "busy after end", busy, 0);
    chk("R3", "sclk idle", spi_sclk, cpol);
    chk("R7", "mosi idle", spi_mosi, 0);
  endtask

  task automatic check_window(string req);
    logic [31:0] d;
    for (int w = 0; w < 8; w++) begin
      rd(8'(8 + 4 * w), d);
      chk(req, $sformatf("window word %0d", w), d, winm[w]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [15:0] l;
    l = 16'hACE1;
    for (int i = 0; i < 256; i++) begin
      rxpat[i] = l[0];
      l = {l[0] ^ l[2] ^ l[3] ^ l[5], l[15:1]};
    end
    for (int w = 0; w < 8; w++) winm[w] = '0;
    opv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "sclk", spi_sclk, 0);
    chk("R1", "mosi", spi_mosi, 0);
    chk("R1", "cs_n", spi_cs_n, 4'hF);
    rd(8'h00, d); chk("R1", "reg 00", d, 0);
    rd(8'h04, d); chk("R1", "reg 04", d, 0);
    rd(8'h28, d); chk("R1", "reg 28", d, 0);
    rd(8'h2C, d); chk("R1", "reg 2C", d, 0);
    rd(8'h38, d); chk("R1", "reg 38", d, 0);

    // R4 R5: 32-bit opcode then 3 transmit bytes, divide by 2, mode 0
    set_mode(0, 0, 0, 0);
    wr(8'h38, 32'h1); csm = 1;
    chk("R9", "cs_n select 0", spi_cs_n, 4'hE);
    opv = 32'h9F12_3456; wr(8'h04, opv);
    winm[0] = 32'h00C3_B2A1; wr(8'h08, winm[0]);
    run_xfer(32, 24, 0, 0, "R4,R5");

    // R6 R7: odd divider, CPOL=1 CPHA=1, LSB first, receive 40 bits
    set_mode(3, 1, 1, 1);
    rd(8'h28, d); chk("R12", "master readback", d, 32'h0003_0038);
    opv = 32'h0000_ABCD; wr(8'h04, opv);
    winm[1] = 32'hDEAD_BEEF; wr(8'h0C, winm[1]);
    run_xfer(16, 0, 40, 0, "R6");
    check_window("R7");

    // R8 R10 R9: half-duplex with pokes in mid-sequence
    set_mode(2, 0, 1, 0);
    run_xfer(8, 16, 16, 1, "R8");
    rd(8'h04, d); chk("R10", "opcode unchanged", d, opv);
    rd(8'h2C, d); chk("R10", "counts unchanged", d, (32'd8 << 24) | (32'd16 << 12) | 32'd16);
    check_window("R8");
    chk("R9", "cs_n after busy write", spi_cs_n, 4'h7);

    // R2: all counts zero
    wr(8'h2C, 32'h0);
    wr(8'h00, 32'h100);
    for (int i = 0; i < 3; i++) begin
      chk("R2", "zero-count busy", busy, 0);
      @(negedge clk);
    end

    // R11: saturated counts
    set_mode(0, 0, 0, 0);
    for (int w = 0; w < 8; w++) begin
      winm[w] = 32'hA5C3_0F96 ^ (32'h1111_1111 * w);
      wr(8'(8 + 4 * w), winm[w]);
    end
    opv = 32'h1357_9BDF; wr(8'h04, opv);
    run_xfer(40, 300, 0, 0, "R11");
    rd(8'h2C, d); chk("R12", "count readback", d, (32'd40 << 24) | 32'd300);

    // R7: receive only, no opcode, CPOL=1 CPHA=0, period 3
    set_mode(1, 1, 0, 0);
    run_xfer(0, 0, 16, 0, "R7");
    check_window("R7");

    // R9: lowest set bit kept
    wr(8'h38, 32'h6); csm = 2;
    chk("R9", "cs_n lowest bit", spi_cs_n, 4'hD);
    wr(8'h38, 32'h0); csm = 0;
    chk("R9", "cs_n released", spi_cs_n, 4'hF);

    // R12: legacy fields
    wr(8'h00, (32'd2 << 19) | 32'd1);
    rd(8'h00, d); chk("R12", "legacy readback", d, 32'h0010_0001);
    chk("R2", "no start from legacy write", busy, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule